// File: doc/BRIEF.md
# Audio core clock and rate generator

This block derives every audio timing reference of a converter subsystem from one fast system clock, using clock enables only. Two single-cycle tick inputs stand for the two possible source clocks: a master clock arriving straight from a pin, and the output of a frequency synthesizer. A four-bit control word chooses the source, states how fast the direct clock runs relative to the base sample rate fs, and gates the whole block on or off. From the chosen ticks a divider produces a core enable that always runs at 256 x fs.

Three independent strobe generators count core enables and emit one-cycle sample strobes for the converter pair, the serial port and the processing engine. Each has its own three-bit rate field selecting fs divided by 0.5, 1, 1.5, 2, 3, 4 or 6. For example, a synthesizer running at 49.152 MHz is taken as 1024 x fs, giving fs = 48 kHz after the forced divide-by-4. Writing a new rate field, or changing source or divider, restarts the affected counter so that the next pulse comes a full new period later.

Top module: `audio_clk_rategen`

## Requirements
- R1: While rst_n is low, and after reset until configured otherwise, core_en and all three strobes are 0.
- R2: With clk_ctrl[3]=0 the block counts mclk_tick pulses and raises core_en once per D of them, where clk_ctrl[2:1] = 00, 01, 10, 11 gives D = 1, 2, 3, 4 (input at 256, 512, 768, 1024 x fs).
- R3: With clk_ctrl[3]=1 the block counts pll_tick pulses and D is 4 whatever clk_ctrl[2:1] holds.
- R4: While clk_ctrl[0]=0, no core_en pulse and no strobe is produced; setting it to 1 restores normal operation.
- R5: A strobe fires once every CORE_MULT x R core_en pulses (CORE_MULT defaults to 256), with rate code 000=0.5, 001=1, 010=1.5, 011=2, 100=3, 101=4, 110=6 giving R.
- R6: Rate code 111 behaves as a ratio of 1.
- R7: conv_rate, port_rate and engine_rate drive conv_strobe, port_strobe and engine_strobe independently of each other.
- R8: A change of a rate field restarts that domain's count: no strobe in the cycle after the change, and the next strobe arrives a full new period of core_en pulses after it.
- R9: Each strobe is one cycle wide and appears in the cycle right after a core_en pulse; a change of source or divider restarts the core count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mclk_tick | input | 1 | One-cycle enable per direct master clock period |
| pll_tick | input | 1 | One-cycle enable per synthesizer output period |
| clk_ctrl | input | 4 | [3] source select, [2:1] direct clock ratio, [0] core enable |
| conv_rate | input | 3 | Converter rate code |
| port_rate | input | 3 | Serial port rate code |
| engine_rate | input | 3 | Processing engine rate code |
| core_en | output | 1 | Core enable pulse at 256 x fs |
| conv_strobe | output | 1 | Converter sample strobe |
| port_strobe | output | 1 | Serial port sample strobe |
| engine_strobe | output | 1 | Processing engine sample strobe |

## Verification
The bench builds the block with CORE_MULT = 16 instead of 256, which shrinks every strobe period sixteen-fold while keeping the ratios between rate codes exact. That brings a full sweep of both sources, all four divider settings and all eight rate codes, with strobe-to-strobe intervals counted in system clocks, within a short run. The direct tick arrives every second clock and the synthesizer tick every clock, so a wrong source choice shows up as a doubled or halved interval.

// File: rtl/audio_clk_pkg.sv
package audio_clk_pkg;

  localparam int unsigned NUM_DOM = 3;
  localparam int unsigned MAX_DIV = 4;
  localparam int unsigned MAX_HALVES = 12;

  typedef enum logic [2:0] {
    RATE_HALF     = 3'd0,
    RATE_ONE      = 3'd1,
    RATE_ONE_HALF = 3'd2,
    RATE_TWO      = 3'd3,
    RATE_THREE    = 3'd4,
    RATE_FOUR     = 3'd5,
    RATE_SIX      = 3'd6,
    RATE_SPARE    = 3'd7
  } rate_code_e;

  // ratio expressed in half steps, so fs/1.5 stays an integer
  function automatic int unsigned rate_halves(input logic [2:0] code);
    case (rate_code_e'(code))
      RATE_HALF:     return 1;
      RATE_ONE:      return 2;
      RATE_ONE_HALF: return 3;
      RATE_TWO:      return 4;
      RATE_THREE:    return 6;
      RATE_FOUR:     return 8;
      RATE_SIX:      return 12;
      default:       return 2;
    endcase
  endfunction

endpackage

// File: rtl/clk_src_select.sv
module clk_src_select
  import audio_clk_pkg::*;
#(
  parameter int unsigned DIV_W = 3
) (
  input  logic             mclk_tick,
  input  logic             pll_tick,
  input  logic [3:0]       clk_ctrl,
  output logic             sel_tick,
  output logic             sel_src,
  output logic [DIV_W-1:0] eff_div
);

  always_comb begin
    sel_src = clk_ctrl[3];
    if (clk_ctrl[3]) begin
      sel_tick = pll_tick;
      eff_div  = DIV_W'(MAX_DIV);
    end else begin
      sel_tick = mclk_tick;
      eff_div  = DIV_W'(clk_ctrl[2:1]) + DIV_W'(1);
    end
  end

endmodule

// File: rtl/core_divider.sv
module core_divider #(
  parameter int unsigned DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic             src,
  input  logic [DIV_W-1:0] div_val,
  output logic             core_en
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W:0]   cfg_q, cfg_d;
  logic             en_q, en_d;
  logic             restart;

  assign cfg_d   = {src, div_val};
  assign restart = (cfg_d != cfg_q);

  always_comb begin
    cnt_d = cnt_q;
    en_d  = 1'b0;
    if (!enable || restart) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == div_val - DIV_W'(1)) begin
        cnt_d = '0;
        en_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cfg_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      cfg_q <= cfg_d;
      en_q  <= en_d;
    end
  end

  assign core_en = en_q;

endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
  import audio_clk_pkg::*;
#(
  parameter int unsigned CORE_MULT = 256,
  parameter int unsigned CNT_W     = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       core_en,
  input  logic [2:0] rate_code,
  output logic       strobe
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] period_m1;
  logic [2:0]       code_q;
  logic             st_q, st_d;
  logic             restart;

  assign period_m1 = CNT_W'((CORE_MULT * rate_halves(rate_code)) / 2 - 1);
  assign restart   = (rate_code != code_q);

  always_comb begin
    cnt_d = cnt_q;
    st_d  = 1'b0;
    if (!enable || restart) begin
      cnt_d = '0;
    end else if (core_en) begin
      if (cnt_q == period_m1) begin
        cnt_d = '0;
        st_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      code_q <= '0;
      st_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      code_q <= rate_code;
      st_q   <= st_d;
    end
  end

  assign strobe = st_q;

endmodule

// File: rtl/audio_clk_rategen.sv
module audio_clk_rategen
  import audio_clk_pkg::*;
#(
  parameter int unsigned CORE_MULT = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mclk_tick,
  input  logic       pll_tick,
  input  logic [3:0] clk_ctrl,
  input  logic [2:0] conv_rate,
  input  logic [2:0] port_rate,
  input  logic [2:0] engine_rate,
  output logic       core_en,
  output logic       conv_strobe,
  output logic       port_strobe,
  output logic       engine_strobe
);

  localparam int unsigned DIV_W = $clog2(MAX_DIV + 1);
  localparam int unsigned CNT_W = $clog2((CORE_MULT * MAX_HALVES) / 2);

  logic [1:0]         rst_pipe;
  logic               rst_int_n;
  logic               sel_tick;
  logic               sel_src;
  logic [DIV_W-1:0]   eff_div;
  logic               core_en_int;
  logic [2:0]         rate_sel [NUM_DOM];
  logic [NUM_DOM-1:0] strobe_vec;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  clk_src_select #(.DIV_W(DIV_W)) u_src (
    .mclk_tick (mclk_tick),
    .pll_tick  (pll_tick),
    .clk_ctrl  (clk_ctrl),
    .sel_tick  (sel_tick),
    .sel_src   (sel_src),
    .eff_div   (eff_div)
  );

  core_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .enable  (clk_ctrl[0]),
    .tick    (sel_tick),
    .src     (sel_src),
    .div_val (eff_div),
    .core_en (core_en_int)
  );

  assign rate_sel[0] = conv_rate;
  assign rate_sel[1] = port_rate;
  assign rate_sel[2] = engine_rate;

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    strobe_gen #(.CORE_MULT(CORE_MULT), .CNT_W(CNT_W)) u_stb (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .enable    (clk_ctrl[0]),
      .core_en   (core_en_int),
      .rate_code (rate_sel[g]),
      .strobe    (strobe_vec[g])
    );
  end

  assign core_en       = core_en_int;
  assign conv_strobe   = strobe_vec[0];
  assign port_strobe   = strobe_vec[1];
  assign engine_strobe = strobe_vec[2];

endmodule

// File: rtl/audio_clk_rategen_chk.sv
module audio_clk_rategen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mclk_tick,
  input logic       pll_tick,
  input logic [3:0] clk_ctrl,
  input logic [2:0] conv_rate,
  input logic       core_en,
  input logic       conv_strobe,
  input logic       port_strobe,
  input logic       engine_strobe
);

  assert_gate_core_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_ctrl[0] |=> !core_en);

  assert_gate_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_ctrl[0] |=> !(conv_strobe || port_strobe || engine_strobe));

  // R2 / R3: a core pulse follows a tick of the selected source
  assert_src_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |-> ($past(clk_ctrl[3]) ? $past(pll_tick) : $past(mclk_tick)));

  assert_after_core_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_strobe || port_strobe || engine_strobe) |-> $past(core_en));

  assert_one_wide_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe |=> !conv_strobe);

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_rate != $past(conv_rate)) |=> !conv_strobe);

endmodule

bind audio_clk_rategen audio_clk_rategen_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mclk_tick     (mclk_tick),
  .pll_tick      (pll_tick),
  .clk_ctrl      (clk_ctrl),
  .conv_rate     (conv_rate),
  .core_en       (core_en),
  .conv_strobe   (conv_strobe),
  .port_strobe   (port_strobe),
  .engine_strobe (engine_strobe)
);

// File: tb/audio_clk_rategen_bench.sv
module audio_clk_rategen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CM         = 16;
  localparam int NVEC       = 10;
  localparam int WATCHDOG   = 190000;

  // fields: [23:22] domain, [21] source, [20:19] ratio bits, [18:16] rate code, [15:0] interval in clocks
  localparam logic [23:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 2'd0, 3'd1, 16'd32},
    {2'd0, 1'b0, 2'd1, 3'd0, 16'd32},
    {2'd1, 1'b0, 2'd2, 3'd2, 16'd144},
    {2'd2, 1'b0, 2'd3, 3'd6, 16'd768},
    {2'd0, 1'b1, 2'd0, 3'd4, 16'd192},
    {2'd1, 1'b1, 2'd3, 3'd5, 16'd256},
    {2'd2, 1'b1, 2'd1, 3'd3, 16'd128},
    {2'd0, 1'b1, 2'd2, 3'd7, 16'd64},
    {2'd1, 1'b0, 2'd0, 3'd7, 16'd32},
    {2'd2, 1'b0, 2'd1, 3'd2, 16'd96}
  };

  logic       clk;
  logic       rst_n;
  logic       mclk_tick;
  logic       pll_tick;
  logic [3:0] clk_ctrl;
  logic [2:0] conv_rate, port_rate, engine_rate;
  logic       core_en, conv_strobe, port_strobe, engine_strobe;

  int  n_checks = 0;
  int  n_fail   = 0;
  int  cyc      = 0;
  bit  done     = 0;

  audio_clk_rategen #(.CORE_MULT(CM)) u_audio_clk_rategen (
    .clk           (clk),
    .rst_n         (rst_n),
    .mclk_tick     (mclk_tick),
    .pll_tick      (pll_tick),
    .clk_ctrl      (clk_ctrl),
    .conv_rate     (conv_rate),
    .port_rate     (port_rate),
    .engine_rate   (engine_rate),
    .core_en       (core_en),
    .conv_strobe   (conv_strobe),
    .port_strobe   (port_strobe),
    .engine_strobe (engine_strobe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // direct ticks every second clock, synthesizer ticks every clock
  always @(negedge clk) begin
    if (!rst_n) mclk_tick <= 1'b0;
    else        mclk_tick <= ~mclk_tick;
  end

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below %0d", cyc, WATCHDOG);
      report();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit strobe_of(input int d);
    case (d)
      0:       return conv_strobe;
      1:       return port_strobe;
      default: return engine_strobe;
    endcase
  endfunction

  function automatic int halves_of(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 4;
      4: return 6;
      5: return 8;
      6: return 12;
      default: return 2;
    endcase
  endfunction

  task automatic apply(input bit src, input int rb, input int c, input int p, input int e);
    @(negedge clk);
    clk_ctrl    = {src, 2'(rb), 1'b1};
    conv_rate   = 3'(c);
    port_rate   = 3'(p);
    engine_rate = 3'(e);
  endtask

  task automatic wait_strobe(input int d, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!strobe_of(d) && n < 6000);
    if (!strobe_of(d)) n = -1;
  endtask

  task automatic measure(input int d, output int interval);
    int n;
    wait_strobe(d, n);
    if (n < 0) begin
      interval = -1;
      return;
    end
    wait_strobe(d, interval);
  endtask

  initial begin
    int iv;
    int n;
    int hits;
    bit prev_core;
    rst_n       = 1'b0;
    pll_tick    = 1'b1;
    clk_ctrl    = 4'b0001;
    conv_rate   = 3'd1;
    port_rate   = 3'd1;
    engine_rate = 3'd1;

    // R1: reset dominates even with enable set
    repeat (5) @(negedge clk);
    check("R1 core_en in reset", int'(core_en), 0);
    check("R1 strobes in reset", int'({conv_strobe, port_strobe, engine_strobe}), 0);
    clk_ctrl = 4'b0000;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 core_en after reset", int'(core_en), 0);

    // table walk: R2 R3 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      int dom, code, other1, other2;
      dom  = int'(VEC[i][23:22]);
      code = int'(VEC[i][18:16]);
      other1 = (code + 3) % 8;
      other2 = (code + 5) % 8;
      case (dom)
        0: apply(VEC[i][21], int'(VEC[i][20:19]), code, other1, other2);
        1: apply(VEC[i][21], int'(VEC[i][20:19]), other1, code, other2);
        default: apply(VEC[i][21], int'(VEC[i][20:19]), other1, other2, code);
      endcase
      measure(dom, iv);
      check($sformatf("R7 table vector %0d (R2/R3/R5/R6)", i), iv, int'(VEC[i][15:0]));
    end

    // full sweep on the converter domain: R2 R3 R5 R6
    for (int s = 0; s < 2; s++) begin
      for (int rb = 0; rb < 4; rb++) begin
        for (int c = 0; c < 8; c++) begin
          int d, sp, exp;
          d   = (s == 1) ? 4 : rb + 1;
          sp  = (s == 1) ? 1 : 2;
          exp = (CM * halves_of(c) / 2) * d * sp;
          apply(s[0], rb, c, 1, 1);
          measure(0, iv);
          check($sformatf("%s src %0d ratio %0d code %0d",
                          (c == 7) ? "R6" : ((s == 1) ? "R3/R5" : "R2/R5"), s, rb, c), iv, exp);
        end
      end
    end

    // R4: disabled block produces nothing, then resumes
    apply(1'b1, 0, 0, 0, 0);
    @(negedge clk);
    clk_ctrl[0] = 1'b0;
    hits = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (core_en || conv_strobe || port_strobe || engine_strobe) hits++;
    end
    check("R4 pulses while disabled", hits, 0);
    clk_ctrl[0] = 1'b1;
    measure(0, iv);
    check("R4 resumes after enable", iv, (CM / 2) * 4);

    // R8: rate change mid period restarts the count
    apply(1'b1, 0, 1, 1, 1);
    measure(0, iv);
    wait_strobe(0, n);
    repeat (40) @(negedge clk);
    conv_rate = 3'd3;
    wait_strobe(0, n);
    check("R8 latency after rate change in window", int'(n >= 124 && n <= 130), 1);
    if (!(n >= 124 && n <= 130)) $display("  R8 detail: latency %0d, expected about %0d", n, CM * 2 * 4);

    // R9: strobe one cycle wide and right after core_en
    apply(1'b0, 1, 2, 2, 2);
    measure(0, iv);
    prev_core = 1'b0;
    n = 0;
    do begin
      prev_core = core_en;
      @(negedge clk);
      n++;
    end while (!conv_strobe && n < 6000);
    check("R9 core_en before strobe", int'(prev_core), 1);
    @(negedge clk);
    check("R9 strobe width one", int'(conv_strobe), 0);

    // R9: divider change restarts core count, new interval applies
    apply(1'b0, 3, 1, 1, 1);
    measure(0, iv);
    check("R9 interval after divider change", iv, CM * 4 * 2);

    if (!done) begin
      done = 1;
      report();
    end
  end

endmodule